// File: doc/BRIEF.md
# Coprocessor Channel Buffer with Vector Handshake

This block is one channel buffer placed between a hardware coprocessor and a register-mapped bus target port. Software, or any other bus master, fills the buffer one word at a time by writing a single data address. The coprocessor drains the buffer with a blocking vector handshake. It presents an item count and holds a request. The block answers with one strobe per delivered item and then a one-cycle completion pulse. The coprocessor side has no address or index lines, so the coprocessor needs no knowledge of how the buffer is built.

Software sees a fill-count register and can program a threshold register. When an enable bit is set, an interrupt level is raised while the fill count equals the threshold. A producer driver uses this to sleep until enough room has been freed. A write to a separate wake address produces a one-cycle wake pulse, which a peer wrapper can use to resume a frozen split transaction. A plain valid/ready request port with a one-cycle response stands in for the bus.

Register selects on `bus_addr`: 0 data (write pushes, read pops), 1 fill count (read-only), 2 threshold, 3 interrupt enable (bit 0), 4 wake (write-only). Selects 5 to 7 are unmapped.

Top module: `chan_fifo_slave`

## Requirements
- R1: While reset is held and after it is released, the fill count is 0, `cp_step`, `cp_done`, `irq`, `wake` and `rsp_valid` are low, and `bus_ready` is high.
- R2: A bus write to select 0 is answered with no error when the buffer holds fewer than DEPTH items, and the word is appended. Items reach the coprocessor in the order in which they were written.
- R3: A bus write to select 0 while the buffer holds DEPTH items is answered with an error, and the fill count does not change. The fill count never exceeds DEPTH.
- R4: A bus read of select 0 returns the oldest item and removes it. If the buffer is empty, or a coprocessor transfer is in progress, the read is answered with an error and nothing is removed.
- R5: A request held high in the idle state with a nonzero `cp_len` starts a transfer of that many items. During the transfer, `cp_step` is high in exactly those cycles in which the buffer is not empty. `cp_data` then carries the oldest item, and that item is consumed at the clock edge.
- R6: `cp_done` is high for exactly one cycle, in the cycle after the edge that consumed the last item. A request with length 0 gives `cp_done` in the cycle after it is seen. A request that is still high while `cp_done` is high does not start a new transfer.
- R7: A read of select 1 returns the fill count. A bus push adds one, a coprocessor step subtracts one, and a push together with a step leaves it unchanged. A write to select 1 is answered with an error.
- R8: `irq` is high exactly when the enable bit (select 3, bit 0) is set and the fill count equals the threshold (select 2). Both registers read back what was last written.
- R9: A bus write to select 4 is answered with no error and raises `wake` for exactly the response cycle; the written data has no effect. A read of select 4 is answered with an error.
- R10: A request is accepted at an edge where `bus_valid` and `bus_ready` are both high. Its response (`rsp_valid`, `rsp_err`, `rsp_rdata`) is present for exactly the following cycle, during which `bus_ready` is low. Selects 5 to 7 are answered with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request present |
| bus_ready | output | 1 | Block can accept a request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | DATA_W | Read data of the response |
| cp_req | input | 1 | Coprocessor transfer request, held until done |
| cp_len | input | LEN_W | Number of items requested |
| cp_step | output | 1 | Item on cp_data is delivered this cycle |
| cp_data | output | DATA_W | Oldest buffered item |
| cp_done | output | 1 | Transfer complete pulse |
| irq | output | 1 | Threshold interrupt level |
| wake | output | 1 | Wake pulse for a peer wrapper |

## Verification
Several properties are checked on every clock cycle:
- `cp_step` never occurs with an empty buffer.
- The fill count never passes DEPTH.
- Responses and `cp_done` last exactly one cycle, and every accepted request gets a response.
- `wake` only appears with an error-free response.
- `irq` always agrees with the enable bit, the fill count and the threshold.

Only the bench scenarios can show that data leaves in write order, that a transfer stalls and resumes as pushes arrive while it is in progress, and that a request which arrives while `bus_ready` is low is dropped. They also show that the error cases leave the stored contents untouched.

// File: rtl/chan_fifo_pkg.sv
package chan_fifo_pkg;

    localparam int BUS_ADDR_W = 3;

    // register selects on the bus port
    typedef enum logic [BUS_ADDR_W-1:0] {
        REG_DATA  = 3'd0,
        REG_FILL  = 3'd1,
        REG_THR   = 3'd2,
        REG_IRQEN = 3'd3,
        REG_WAKE  = 3'd4
    } reg_sel_e;

    // coprocessor-side handshake state
    typedef enum logic {
        VEC_IDLE = 1'b0,
        VEC_XFER = 1'b1
    } vec_state_e;

endpackage

// File: rtl/chan_fifo_store.sv
module chan_fifo_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic [CNT_W-1:0]  fill_o
);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } store_t;

    store_t st_d, st_q;
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.wr = (st_q.wr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (pop_i) begin
            st_d.rd = (st_q.rd == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        case ({push_i, pop_i})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_i) begin
            mem_q[st_q.wr] <= wdata_i;
        end
    end

    assign head_o = mem_q[st_q.rd];
    assign fill_o = st_q.cnt;

endmodule

// File: rtl/chan_vec_ctrl.sv
module chan_vec_ctrl
    import chan_fifo_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             avail_i,
    output logic             step_o,
    output logic             done_o,
    output logic             busy_o
);

    typedef struct packed {
        vec_state_e       st;
        logic [LEN_W-1:0] rem;
        logic             done;
    } vec_t;

    vec_t v_d, v_q;

    always_comb begin
        v_d      = v_q;
        v_d.done = 1'b0;
        step_o   = (v_q.st == VEC_XFER) && avail_i;
        case (v_q.st)
            VEC_IDLE: begin
                // a request still high during the done cycle is the old one
                if (req_i && !v_q.done) begin
                    if (len_i == '0) begin
                        v_d.done = 1'b1;
                    end else begin
                        v_d.st  = VEC_XFER;
                        v_d.rem = len_i;
                    end
                end
            end
            VEC_XFER: begin
                if (step_o) begin
                    if (v_q.rem == LEN_W'(1)) begin
                        v_d.st   = VEC_IDLE;
                        v_d.done = 1'b1;
                        v_d.rem  = '0;
                    end else begin
                        v_d.rem = v_q.rem - 1'b1;
                    end
                end
            end
            default: v_d.st = VEC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '{st: VEC_IDLE, rem: '0, done: 1'b0};
        end else begin
            v_q <= v_d;
        end
    end

    assign done_o = v_q.done;
    assign busy_o = (v_q.st == VEC_XFER);

endmodule

// File: rtl/chan_fifo_slave.sv
module chan_fifo_slave
    import chan_fifo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    parameter int LEN_W  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid,
    output logic                  bus_ready,
    input  logic                  bus_write,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic                  rsp_valid,
    output logic                  rsp_err,
    output logic [DATA_W-1:0]     rsp_rdata,
    input  logic                  cp_req,
    input  logic [LEN_W-1:0]      cp_len,
    output logic                  cp_step,
    output logic [DATA_W-1:0]     cp_data,
    output logic                  cp_done,
    output logic                  irq,
    output logic                  wake
);

    typedef struct packed {
        logic              rsp_v;
        logic              rsp_err;
        logic [DATA_W-1:0] rsp_data;
        logic [CNT_W-1:0]  thr;
        logic              irq_en;
        logic              irq;
        logic              wake;
    } regs_t;

    regs_t r_d, r_q;

    logic              accept;
    logic              push;
    logic              bus_pop;
    logic              busy;
    logic [DATA_W-1:0] head;
    logic [CNT_W-1:0]  fill;
    logic [CNT_W-1:0]  fill_nx;

    chan_fifo_store #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (push),
        .wdata_i(bus_wdata),
        .pop_i  (bus_pop | cp_step),
        .head_o (head),
        .fill_o (fill)
    );

    chan_vec_ctrl #(
        .LEN_W(LEN_W)
    ) u_vec (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (cp_req),
        .len_i  (cp_len),
        .avail_i(fill != '0),
        .step_o (cp_step),
        .done_o (cp_done),
        .busy_o (busy)
    );

    always_comb begin
        r_d          = r_q;
        accept       = bus_valid && !r_q.rsp_v;
        push         = 1'b0;
        bus_pop      = 1'b0;
        r_d.rsp_v    = accept;
        r_d.rsp_err  = 1'b0;
        r_d.rsp_data = '0;
        r_d.wake     = 1'b0;

        if (accept) begin
            case (bus_addr)
                REG_DATA: begin
                    if (bus_write) begin
                        if (fill < CNT_W'(DEPTH)) push = 1'b1;
                        else                      r_d.rsp_err = 1'b1;
                    end else if (fill != '0 && !busy) begin
                        bus_pop      = 1'b1;
                        r_d.rsp_data = head;
                    end else begin
                        r_d.rsp_err = 1'b1;
                    end
                end
                REG_FILL: begin
                    if (bus_write) r_d.rsp_err  = 1'b1;
                    else           r_d.rsp_data = DATA_W'(fill);
                end
                REG_THR: begin
                    if (bus_write) r_d.thr      = bus_wdata[CNT_W-1:0];
                    else           r_d.rsp_data = DATA_W'(r_q.thr);
                end
                REG_IRQEN: begin
                    if (bus_write) r_d.irq_en   = bus_wdata[0];
                    else           r_d.rsp_data = DATA_W'(r_q.irq_en);
                end
                REG_WAKE: begin
                    if (bus_write) r_d.wake    = 1'b1;
                    else           r_d.rsp_err = 1'b1;
                end
                default: r_d.rsp_err = 1'b1;
            endcase
        end

        // fill count after this edge, for the registered interrupt level
        fill_nx = fill;
        if (push && !(bus_pop || cp_step))      fill_nx = fill + 1'b1;
        else if (!push && (bus_pop || cp_step)) fill_nx = fill - 1'b1;
        r_d.irq = r_d.irq_en && (fill_nx == r_d.thr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_ready = !r_q.rsp_v;
    assign rsp_valid = r_q.rsp_v;
    assign rsp_err   = r_q.rsp_err;
    assign rsp_rdata = r_q.rsp_data;
    assign cp_data   = head;
    assign irq       = r_q.irq;
    assign wake      = r_q.wake;

endmodule

// File: rtl/chan_fifo_slave_chk.sv
module chan_fifo_slave_chk #(
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic             bus_ready,
    input logic             rsp_valid,
    input logic             rsp_err,
    input logic             cp_step,
    input logic             cp_done,
    input logic             irq,
    input logic             wake,
    input logic [CNT_W-1:0] fill,
    input logic [CNT_W-1:0] thr,
    input logic             irq_en
);

    // R5
    step_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cp_step |-> fill != '0);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

    // R10
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10
    accept_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready) |=> rsp_valid);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cp_done |=> !cp_done);

    // R9
    wake_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (rsp_valid && !rsp_err));

    // R8
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (irq_en && (fill == thr)));

endmodule

bind chan_fifo_slave chan_fifo_slave_chk #(
    .DEPTH(DEPTH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(bus_valid),
    .bus_ready(bus_ready),
    .rsp_valid(rsp_valid),
    .rsp_err  (rsp_err),
    .cp_step  (cp_step),
    .cp_done  (cp_done),
    .irq      (irq),
    .wake     (wake),
    .fill     (fill),
    .thr      (r_q.thr),
    .irq_en   (r_q.irq_en)
);

// File: tb/test_chan_fifo_slave.sv
module test_chan_fifo_slave;

    localparam int DATA_W = 32;
    localparam int DEPTH  = 8;
    localparam int LEN_W  = 8;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_ready;
    logic              bus_write = 1'b0;
    logic [2:0]        bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              rsp_valid, rsp_err;
    logic [DATA_W-1:0] rsp_rdata;
    logic              cp_req = 1'b0;
    logic [LEN_W-1:0]  cp_len = '0;
    logic              cp_step, cp_done, irq, wake;
    logic [DATA_W-1:0] cp_data;

    always #4 clk = ~clk;

    chan_fifo_slave #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LEN_W(LEN_W)) i_chan_fifo_slave (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .cp_req(cp_req), .cp_len(cp_len), .cp_step(cp_step), .cp_data(cp_data),
        .cp_done(cp_done), .irq(irq), .wake(wake)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // ---------------- behavioural reference model ----------------
    logic [DATA_W-1:0] q[$];
    bit                m_busy, m_done, m_en, m_rv, m_re, m_wake, started;
    int                m_rem, m_thr;
    logic [DATA_W-1:0] m_rd;

    always @(posedge clk) begin : model
        bit stp, acc, push, bpop, nrv, nre, nwk, nd;
        logic [DATA_W-1:0] nrd;
        if (!rst_n) begin
            q.delete();
            m_busy = 0; m_done = 0; m_en = 0; m_rv = 0; m_re = 0; m_wake = 0;
            m_rem = 0; m_thr = 0; m_rd = '0;
        end else begin
            stp = m_busy && (q.size() > 0);
            acc = bus_valid && !m_rv;
            push = 0; bpop = 0; nrv = acc; nre = 0; nrd = '0; nwk = 0; nd = 0;
            if (acc) begin
                case (bus_addr)
                    3'd0: if (bus_write) begin
                              if (q.size() < DEPTH) push = 1; else nre = 1;
                          end else if (q.size() > 0 && !m_busy) begin
                              bpop = 1; nrd = q[0];
                          end else nre = 1;
                    3'd1: if (bus_write) nre = 1; else nrd = DATA_W'(q.size());
                    3'd2: if (bus_write) m_thr = int'(bus_wdata[CNT_W-1:0]);
                          else nrd = DATA_W'(m_thr);
                    3'd3: if (bus_write) m_en = bus_wdata[0]; else nrd = DATA_W'(m_en);
                    3'd4: if (bus_write) nwk = 1; else nre = 1;
                    default: nre = 1;
                endcase
            end
            if (m_busy) begin
                if (stp) begin
                    if (m_rem == 1) begin m_busy = 0; nd = 1; end
                    else m_rem--;
                end
            end else if (cp_req && !m_done) begin
                if (cp_len == 0) nd = 1;
                else begin m_busy = 1; m_rem = int'(cp_len); end
            end
            if (stp)  void'(q.pop_front());
            if (bpop) void'(q.pop_front());
            if (push) q.push_back(bus_wdata);
            m_done = nd; m_rv = nrv; m_re = nre; m_rd = nrd; m_wake = nwk;
        end
        started = 1;
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        bit es;
        if (started) begin
            es = m_busy && (q.size() > 0);
            chk(bus_ready === !m_rv, "R10", "bus_ready", bus_ready, !m_rv);
            chk(rsp_valid === m_rv, "R10", "rsp_valid", rsp_valid, m_rv);
            if (m_rv) begin
                chk(rsp_err === m_re, "R3/R4", "rsp_err", rsp_err, m_re);
                if (!m_re) chk(rsp_rdata === m_rd, "R7", "rsp_rdata", rsp_rdata, m_rd);
            end
            chk(cp_step === es, "R5", "cp_step", cp_step, es);
            if (es) chk(cp_data === q[0], "R2", "cp_data order", cp_data, q[0]);
            chk(cp_done === m_done, "R6", "cp_done", cp_done, m_done);
            chk(irq === (m_en && q.size() == m_thr), "R8", "irq", irq, m_en && q.size() == m_thr);
            chk(wake === m_wake, "R9", "wake", wake, m_wake);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic bus_op(input bit wr, input logic [2:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    // response is visible at the negedge where bus_op returns
    task automatic bus_rd_chk(input logic [2:0] a, input logic [DATA_W-1:0] exp, input string tag);
        bus_op(1'b0, a, '0);
        chk(rsp_valid === 1'b1 && rsp_err === 1'b0, tag, "read response ok", {rsp_valid, rsp_err}, 2'b10);
        chk(rsp_rdata === exp, tag, "read data", rsp_rdata, exp);
    endtask

    task automatic bus_err_chk(input bit wr, input logic [2:0] a, input string tag);
        bus_op(wr, a, 32'h5a5a_5a5a);
        chk(rsp_valid === 1'b1 && rsp_err === 1'b1, tag, "error response", {rsp_valid, rsp_err}, 2'b11);
    endtask

    task automatic cp_run(input int len);
        @(negedge clk);
        cp_req = 1'b1; cp_len = LEN_W'(len);
        do @(negedge clk); while (cp_done !== 1'b1);
        cp_req = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state while held
        chk(rsp_valid === 0 && cp_step === 0 && cp_done === 0 && irq === 0 && wake === 0,
            "R1", "outputs in reset", {rsp_valid, cp_step, cp_done, irq, wake}, 0);
        chk(bus_ready === 1, "R1", "ready in reset", bus_ready, 1);
        rst_n = 1'b1;
        bus_rd_chk(3'd1, 0, "R1");

        // R4 empty read
        bus_err_chk(1'b0, 3'd0, "R4");

        // R8 program threshold and enable
        bus_op(1'b1, 3'd2, 32'd3);
        bus_op(1'b1, 3'd3, 32'd1);
        chk(irq === 0, "R8", "irq below threshold", irq, 0);
        for (int i = 1; i <= 3; i++) bus_op(1'b1, 3'd0, 32'h11 * i);
        chk(irq === 1, "R8", "irq at threshold", irq, 1);
        bus_rd_chk(3'd1, 3, "R7");

        // fill to full, then overflow (R2, R3)
        for (int i = 4; i <= 8; i++) bus_op(1'b1, 3'd0, 32'h11 * i);
        chk(irq === 0, "R8", "irq above threshold", irq, 0);
        bus_err_chk(1'b1, 3'd0, "R3");
        bus_rd_chk(3'd1, DEPTH, "R3");

        // bus pop of oldest (R4)
        bus_rd_chk(3'd0, 32'h11, "R4");
        bus_rd_chk(3'd1, 7, "R4");

        // coprocessor transfer (R5, R6)
        cp_run(3);
        bus_rd_chk(3'd1, 4, "R5");

        // zero-length request (R6)
        cp_run(0);
        bus_rd_chk(3'd1, 4, "R6");

        // stalled transfer resumes on pushes; bus pop refused while busy (R4, R5, R7)
        fork
            cp_run(6);
            begin
                repeat (2) @(negedge clk);
                bus_err_chk(1'b0, 3'd0, "R4");
                bus_op(1'b1, 3'd0, 32'hA1);
                bus_op(1'b1, 3'd0, 32'hA2);
            end
        join
        bus_rd_chk(3'd1, 0, "R7");

        // back-to-back valid: middle request dropped (R10)
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = 3'd0; bus_wdata = 32'hC1;
        @(negedge clk);
        chk(bus_ready === 0, "R10", "ready low in response cycle", bus_ready, 0);
        bus_wdata = 32'hC2;
        @(negedge clk);
        bus_wdata = 32'hC3;
        @(negedge clk);
        bus_valid = 0;
        bus_rd_chk(3'd1, 2, "R10");

        // wake and error selects (R9, R7, R10)
        bus_op(1'b1, 3'd4, 32'hFFFF_FFFF);
        chk(wake === 1, "R9", "wake pulse", wake, 1);
        @(negedge clk);
        chk(wake === 0, "R9", "wake single cycle", wake, 0);
        bus_rd_chk(3'd1, 2, "R9");
        bus_err_chk(1'b0, 3'd4, "R9");
        bus_err_chk(1'b1, 3'd1, "R7");
        bus_err_chk(1'b0, 3'd6, "R10");
        bus_err_chk(1'b1, 3'd7, "R10");

        // drain: order of kept items checked by model (R2)
        cp_run(2);

        // register read-back and zero threshold (R8)
        bus_rd_chk(3'd2, 3, "R8");
        bus_rd_chk(3'd3, 1, "R8");
        bus_op(1'b1, 3'd2, 32'd0);
        chk(irq === 1, "R8", "irq at empty threshold", irq, 1);
        bus_op(1'b1, 3'd3, 32'd0);
        chk(irq === 0, "R8", "irq masked", irq, 0);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule